// File: doc/BRIEF.md
# CAN Fault-Confinement State Tracker

This block holds the transmit and receive error counters of a CAN node and derives the node's fault-confinement state from them: error active, error warning, error passive or bus off. A protocol engine, which is outside this block, reports each transmit or receive error and each successful transfer as a one-cycle strobe. The block updates the counters, classifies the result, and publishes a 32-bit status word. Whenever the classified state moves, it emits a one-cycle event that carries the new state and both counters.

On entering bus off, the block freezes the counters and requests that every pending transmit slot be marked for abort. Recovery from bus off needs two steps. Software must first pass through reset mode, which means raising and then lowering the reset-mode input. Then the bus has to show 128 idle sequences of 11 consecutive recessive bits, as reported by a bit-time strobe and a recessive-sample flag. When the grace period ends, the counters clear and the state returns to error active. In the same cycle the block raises a drain request, so the transmit queue can flush the frames that were aborted and left waiting. Frames are not flushed any earlier than this.

Top module: `can_fault_confine`

## Requirements
- R1: The status word carries the receive counter in bits 7:0, the transmit counter in bits 15:8, error warning in bit 17, error passive in bit 18 and bus off in bit 19. Every other bit reads zero, and all bits read zero after reset.
- R2: A transmit error adds 8 to the transmit counter and a receive error adds 1 to the receive counter. A success strobe subtracts 1, with a floor of 0. When an error and a success hit the same counter in the same cycle, the error applies and the success is ignored. The receive counter saturates at 255.
- R3: Error warning (bit 17) is reported when either counter is 96 or more, unless a higher-priority state applies. At 95 or below on both counters, the state is error active.
- R4: Error passive (bit 18) is reported when either counter exceeds 127. It takes priority over warning, and at most one of bits 17 to 19 is set at any time.
- R5: A transmit error that would take the transmit counter past 255 enters bus off. The counter then reads 255, bit 19 is set, and abort_all_o pulses for one cycle in the same cycle.
- R6: Every change of the classified state produces exactly one evt_valid_o pulse, in the cycle the status word shows the new state. The pulse carries the state code (0 active, 1 warning, 2 passive, 3 bus off) and both counters as shown in the status word. No pulse occurs without a state change.
- R7: While in bus off, all error and success strobes are ignored and both counters hold.
- R8: Bus-off recovery counts nothing until reset mode has been entered and then left after bus off was reached. While reset mode is high, the recovery progress is held at zero.
- R9: Recovery completes on the recessive bit that ends the 128th idle run of 11 recessive bit times. In that cycle both counters read 0, the state returns to error active with an event, and drain_o pulses for one cycle.
- R10: During recovery, a dominant bit restarts the current 11-bit run but keeps the completed runs. Recessive samples without a bit-time strobe are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_mode_i | input | 1 | Controller held in reset mode |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| bit_tick_i | input | 1 | One pulse per bit time |
| bit_recessive_i | input | 1 | Sampled bit is recessive, qualified by bit_tick_i |
| status_o | output | 32 | Counters and state flags |
| evt_valid_o | output | 1 | State-change event pulse |
| evt_state_o | output | 2 | State code of the event |
| evt_tec_o | output | 8 | Transmit counter carried by the event |
| evt_rec_o | output | 8 | Receive counter carried by the event |
| abort_all_o | output | 1 | Mark all pending transmit slots for abort |
| drain_o | output | 1 | Grace period over; flush aborted frames |

## Verification
The bench targets the threshold edges: 95 against 96, 127 against 128, and 248 followed by one more transmit error. A design with an off-by-one compare would report warning or passive one error early or late. A design that wraps the transmit counter would fall back to error active instead of reaching bus off.

In recovery, the bench stops one bit short of the full count. It then inserts a recessive sample without a bit-time strobe and a dominant bit, and finishes with exactly 11 more recessive bits. A design that counted untimed samples, discarded the completed runs, or failed to restart the partial run would release bus off at the wrong moment.

The bench also runs long recessive stretches before reset mode has been cycled and while it is held high. A design that started the grace period without that handshake would leave bus off early.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARN    = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_state_e;

    localparam int STAT_W        = 32;
    localparam int STAT_REC_LSB  = 0;
    localparam int STAT_TEC_LSB  = 8;
    localparam int STAT_FIELD_W  = 8;
    localparam int STAT_WARN_BIT = 17;
    localparam int STAT_PASS_BIT = 18;
    localparam int STAT_BOFF_BIT = 19;

endpackage

// File: rtl/can_err_counter.sv
module can_err_counter #(
    parameter int CNT_W = 8,
    parameter int INC   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             ok_i,
    input  logic             freeze_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nx_o
);

    localparam logic [CNT_W:0] INC_V = (CNT_W+1)'(INC);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + INC_V;
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (!freeze_i) begin
            if (err_i) begin
                // saturate on carry out
                cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
            end else if (ok_i && (cnt_q != '0)) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o    = cnt_q;
    assign cnt_nx_o = cnt_d;

endmodule

// File: rtl/can_fc_classify.sv
module can_fc_classify
    import can_fc_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127
) (
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  logic             busoff_i,
    output fc_state_e        state_o
);

    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIMIT);
    localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_LIMIT);

    always_comb begin
        if (busoff_i)
            state_o = FC_BUSOFF;
        else if ((tec_i > PASS_V) || (rec_i > PASS_V))
            state_o = FC_PASSIVE;
        else if ((tec_i >= WARN_V) || (rec_i >= WARN_V))
            state_o = FC_WARN;
        else
            state_o = FC_ACTIVE;
    end

endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery #(
    parameter int IDLE_BITS = 11,
    parameter int IDLE_RUNS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busoff_i,
    input  logic reset_mode_i,
    input  logic bit_tick_i,
    input  logic bit_recessive_i,
    output logic done_o
);

    localparam int BIT_W = $clog2(IDLE_BITS + 1);
    localparam int RUN_W = $clog2(IDLE_RUNS + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(IDLE_BITS - 1);
    localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(IDLE_RUNS - 1);

    typedef struct packed {
        logic             armed;
        logic [BIT_W-1:0] run;
        logic [RUN_W-1:0] runs;
    } rcv_s;

    rcv_s q, d;
    logic done_d;

    always_comb begin
        d      = q;
        done_d = 1'b0;
        if (!busoff_i) begin
            d = '0;
        end else if (reset_mode_i) begin
            // handshake seen; progress held at zero
            d.armed = 1'b1;
            d.run   = '0;
            d.runs  = '0;
        end else if (q.armed && bit_tick_i) begin
            if (!bit_recessive_i) begin
                d.run = '0;
            end else if (q.run == LAST_BIT) begin
                d.run = '0;
                if (q.runs == LAST_RUN) begin
                    done_d = 1'b1;
                    d      = '0;
                end else begin
                    d.runs = q.runs + 1'b1;
                end
            end else begin
                d.run = q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = done_d;

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int TX_INC        = 8,
    parameter int RX_INC        = 1,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127,
    parameter int IDLE_BITS     = 11,
    parameter int IDLE_RUNS     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_mode_i,
    input  logic              tx_err_i,
    input  logic              rx_err_i,
    input  logic              tx_ok_i,
    input  logic              rx_ok_i,
    input  logic              bit_tick_i,
    input  logic              bit_recessive_i,
    output logic [31:0]       status_o,
    output logic              evt_valid_o,
    output logic [1:0]        evt_state_o,
    output logic [CNT_W-1:0]  evt_tec_o,
    output logic [CNT_W-1:0]  evt_rec_o,
    output logic              abort_all_o,
    output logic              drain_o
);

    localparam int N_CNT  = 2;
    localparam int TX_IDX = 0;
    localparam int RX_IDX = 1;

    typedef struct packed {
        fc_state_e state;
        logic      busoff;
        logic      evt;
        logic      abort;
        logic      drain;
    } ctl_s;

    localparam ctl_s CTL_RST = '{state: FC_ACTIVE, busoff: 1'b0, evt: 1'b0,
                                 abort: 1'b0, drain: 1'b0};

    ctl_s q, d;

    logic [N_CNT-1:0] err_v, ok_v;
    logic [CNT_W-1:0] cnt_q  [N_CNT];
    logic [CNT_W-1:0] cnt_nx [N_CNT];
    logic [CNT_W:0]   tx_sum;
    logic             tx_ovf, rec_done, busoff_nx;
    fc_state_e        cls_state;

    assign err_v = {rx_err_i, tx_err_i};
    assign ok_v  = {rx_ok_i,  tx_ok_i};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        localparam int INC_G = (g == TX_IDX) ? TX_INC : RX_INC;
        can_err_counter #(
            .CNT_W (CNT_W),
            .INC   (INC_G)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .err_i    (err_v[g]),
            .ok_i     (ok_v[g]),
            .freeze_i (q.busoff),
            .clear_i  (rec_done),
            .cnt_o    (cnt_q[g]),
            .cnt_nx_o (cnt_nx[g])
        );
    end

    can_busoff_recovery #(
        .IDLE_BITS (IDLE_BITS),
        .IDLE_RUNS (IDLE_RUNS)
    ) u_rcv (
        .clk             (clk),
        .rst_n           (rst_n),
        .busoff_i        (q.busoff),
        .reset_mode_i    (reset_mode_i),
        .bit_tick_i      (bit_tick_i),
        .bit_recessive_i (bit_recessive_i),
        .done_o          (rec_done)
    );

    // transmit counter carry out marks the bus-off transition
    assign tx_sum    = {1'b0, cnt_q[TX_IDX]} + (CNT_W+1)'(TX_INC);
    assign tx_ovf    = tx_err_i && !q.busoff && tx_sum[CNT_W];
    assign busoff_nx = q.busoff ? !rec_done : tx_ovf;

    can_fc_classify #(
        .CNT_W         (CNT_W),
        .WARN_LIMIT    (WARN_LIMIT),
        .PASSIVE_LIMIT (PASSIVE_LIMIT)
    ) u_cls (
        .tec_i    (cnt_nx[TX_IDX]),
        .rec_i    (cnt_nx[RX_IDX]),
        .busoff_i (busoff_nx),
        .state_o  (cls_state)
    );

    always_comb begin
        d        = q;
        d.busoff = busoff_nx;
        d.state  = cls_state;
        d.evt    = (cls_state != q.state);
        d.abort  = tx_ovf;
        d.drain  = rec_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    always_comb begin
        status_o = '0;
        status_o[STAT_REC_LSB +: STAT_FIELD_W] = STAT_FIELD_W'(cnt_q[RX_IDX]);
        status_o[STAT_TEC_LSB +: STAT_FIELD_W] = STAT_FIELD_W'(cnt_q[TX_IDX]);
        status_o[STAT_WARN_BIT] = (q.state == FC_WARN);
        status_o[STAT_PASS_BIT] = (q.state == FC_PASSIVE);
        status_o[STAT_BOFF_BIT] = (q.state == FC_BUSOFF);
    end

    assign evt_valid_o = q.evt;
    assign evt_state_o = q.state;
    assign evt_tec_o   = cnt_q[TX_IDX];
    assign evt_rec_o   = cnt_q[RX_IDX];
    assign abort_all_o = q.abort;
    assign drain_o     = q.drain;

endmodule

// File: rtl/can_fault_confine_chk.sv
module can_fault_confine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reset_mode_i,
    input logic [31:0] status_o,
    input logic        evt_valid_o,
    input logic [1:0]  evt_state_o,
    input logic        abort_all_o,
    input logic        drain_o
);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[31:20] == 12'h0) && !status_o[16])
        else $error("R1 reserved status bits set");

    a_r4_single_state_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_o[19:17]))
        else $error("R4 more than one state flag");

    a_r6_event_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[19:17] != $past(status_o[19:17])) |-> evt_valid_o)
        else $error("R6 state changed without event");

    a_r6_no_spurious_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> (status_o[19:17] != $past(status_o[19:17])))
        else $error("R6 event without state change");

    a_r6_event_code: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> ((evt_state_o == 2'd3) == status_o[19]))
        else $error("R6 event code disagrees with bus-off flag");

    a_r5_abort_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        abort_all_o |-> (status_o[19] && !$past(status_o[19]) && status_o[15:8] == 8'hFF))
        else $error("R5 abort request outside bus-off entry");

    a_r7_frozen_in_busoff: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[19] && $past(status_o[19])) |-> $stable(status_o[15:0]))
        else $error("R7 counters moved in bus off");

    a_r8_hold_in_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_mode_i && status_o[19]) |=> status_o[19])
        else $error("R8 left bus off while in reset mode");

    a_r9_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        drain_o |-> (status_o[15:0] == 16'h0 && !status_o[19] && $past(status_o[19])))
        else $error("R9 drain without clean exit from bus off");

endmodule

bind can_fault_confine can_fault_confine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_mode_i (reset_mode_i),
    .status_o     (status_o),
    .evt_valid_o  (evt_valid_o),
    .evt_state_o  (evt_state_o),
    .abort_all_o  (abort_all_o),
    .drain_o      (drain_o)
);

// File: tb/can_fault_confine_tb.sv
module can_fault_confine_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_mode = 1'b0;
    logic        tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0;
    logic        tick = 1'b0, recsv = 1'b0;
    logic [31:0] status;
    logic        evt_valid, abort_all, drain;
    logic [1:0]  evt_state;
    logic [7:0]  evt_tec, evt_rec;

    always #2.5 clk = ~clk;

    can_fault_confine u_dut (
        .clk (clk), .rst_n (rst_n), .reset_mode_i (reset_mode),
        .tx_err_i (tx_err), .rx_err_i (rx_err), .tx_ok_i (tx_ok), .rx_ok_i (rx_ok),
        .bit_tick_i (tick), .bit_recessive_i (recsv),
        .status_o (status), .evt_valid_o (evt_valid), .evt_state_o (evt_state),
        .evt_tec_o (evt_tec), .evt_rec_o (evt_rec),
        .abort_all_o (abort_all), .drain_o (drain)
    );

    typedef struct { int kind; int st; int tec; int rec; } item_t;
    item_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    int m_tec, m_rec, m_state, m_run, m_runs;
    bit m_bo, m_armed;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int classify();
        if (m_bo) return 3;
        if (m_tec > 127 || m_rec > 127) return 2;
        if (m_tec >= 96 || m_rec >= 96) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] model_status();
        logic [31:0] s;
        int st;
        st = classify();
        s = 32'(m_rec) | (32'(m_tec) << 8);
        s[17] = (st == 1);
        s[18] = (st == 2);
        s[19] = (st == 3);
        return s;
    endfunction

    // driver: update reference model, push expected items, apply one cycle of stimulus
    task automatic step(bit te, bit re, bit to, bit ro, bit tk, bit rv);
        bit was_bo, entered, done;
        int ns;
        @(negedge clk);
        was_bo = m_bo; entered = 0; done = 0;
        if (!was_bo) begin
            if (te) begin
                if (m_tec + 8 > 255) begin m_bo = 1; m_tec = 255; entered = 1; end
                else m_tec += 8;
            end else if (to && m_tec > 0) m_tec--;
            if (re) m_rec = (m_rec < 255) ? m_rec + 1 : 255;
            else if (ro && m_rec > 0) m_rec--;
        end else if (reset_mode) begin
            m_armed = 1; m_run = 0; m_runs = 0;
        end else if (m_armed && tk) begin
            if (!rv) m_run = 0;
            else if (m_run == 10) begin
                m_run = 0;
                if (m_runs == 127) begin
                    done = 1; m_bo = 0; m_tec = 0; m_rec = 0; m_armed = 0; m_runs = 0;
                end else m_runs++;
            end else m_run++;
        end
        ns = classify();
        if (ns != m_state) exp_q.push_back('{0, ns, m_tec, m_rec});
        m_state = ns;
        if (entered) exp_q.push_back('{1, 3, m_tec, m_rec});
        if (done)    exp_q.push_back('{2, 0, 0, 0});
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; tick = tk; recsv = rv;
        @(posedge clk);
        #2;
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; tick = 0; recsv = 0;
    endtask

    task automatic do_reset();
        chk(exp_q.size() == 0, "R6", "events outstanding before reset", exp_q.size(), 0);
        rst_n = 0;
        m_tec = 0; m_rec = 0; m_state = 0; m_run = 0; m_runs = 0; m_bo = 0; m_armed = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic chk_status(string req);
        logic [31:0] e;
        e = model_status();
        chk(status === e, req, "status word", status, e);
    endtask

    // monitor: compare event, abort and drain pulses against the scoreboard queue
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (evt_valid) begin
                if (exp_q.size() == 0) chk(0, "R6", "unexpected event", evt_state, 0);
                else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.kind == 0, "R6", "event where other pulse expected", 0, it.kind);
                    chk(evt_state == 2'(it.st), "R6", "event state", evt_state, it.st);
                    chk(evt_tec == 8'(it.tec) && evt_rec == 8'(it.rec), "R6",
                        "event counters", {evt_tec, evt_rec}, {8'(it.tec), 8'(it.rec)});
                end
            end
            if (abort_all) begin
                if (exp_q.size() == 0) chk(0, "R5", "unexpected abort", 1, 0);
                else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.kind == 1, "R5", "abort pulse kind", 1, it.kind);
                end
            end
            if (drain) begin
                if (exp_q.size() == 0) chk(0, "R9", "unexpected drain", 1, 0);
                else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.kind == 2, "R9", "drain pulse kind", 2, it.kind);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(status === 32'h0, "R1", "status after reset", status, 0);
        chk(!evt_valid && !abort_all && !drain, "R1", "pulses after reset",
            {evt_valid, abort_all, drain}, 0);

        // R3: warning boundary on the receive counter
        for (int i = 0; i < 95; i++) step(0, 1, 0, 0, 0, 0);
        chk_status("R3");
        chk(status[17] == 0, "R3", "no warning at 95", status[17], 0);
        step(0, 1, 0, 0, 0, 0);
        chk(status[17] == 1, "R3", "warning at 96", status[17], 1);
        // R4: passive boundary
        for (int i = 0; i < 31; i++) step(0, 1, 0, 0, 0, 0);
        chk(status[18] == 0, "R4", "no passive at 127", status[18], 0);
        step(0, 1, 0, 0, 0, 0);
        chk(status[18] == 1 && status[17] == 0, "R4", "passive at 128", status[19:17], 3'b010);
        step(0, 0, 0, 1, 0, 0);
        chk_status("R4");
        for (int i = 0; i < 32; i++) step(0, 0, 0, 1, 0, 0);
        chk(status[19:17] == 3'b000, "R3", "active at 95", status[19:17], 0);
        // R2: error wins over success in the same cycle
        step(0, 1, 0, 1, 0, 0);
        chk_status("R2");
        step(1, 0, 1, 0, 0, 0);
        chk(status[15:8] == 8'd8, "R2", "tx error beats success", status[15:8], 8);

        do_reset();
        // R2: floor at zero
        step(0, 0, 1, 1, 0, 0);
        chk(status === 32'h0, "R2", "success at zero", status, 0);
        // R4: passive over warning with mixed counters
        for (int i = 0; i < 100; i++) step(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0);
        chk_status("R4");
        chk(status[19:17] == 3'b010, "R4", "tec 128 rec 100", status[19:17], 3'b010);

        do_reset();
        // R5: bus-off entry
        for (int i = 0; i < 31; i++) step(1, 0, 0, 0, 0, 0);
        chk(status[15:8] == 8'd248 && status[19] == 0, "R5", "tec 248 not bus off",
            status[19:8], 12'h0F8 | (1 << 10));
        step(1, 0, 0, 0, 0, 0);
        chk_status("R5");
        chk(status[19] == 1 && status[15:8] == 8'hFF, "R5", "bus off at overflow",
            status[19:8], 12'h8FF);
        // R7: strobes ignored in bus off
        step(1, 1, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        chk_status("R7");
        chk(status[15:0] == 16'hFF00, "R7", "counters frozen", status[15:0], 16'hFF00);
        // R8: no recovery without the reset-mode handshake
        for (int i = 0; i < 1500; i++) step(0, 0, 0, 0, 1, 1);
        chk(status[19] == 1, "R8", "bus off held before reset mode", status[19], 1);
        reset_mode = 1;
        for (int i = 0; i < 1500; i++) step(0, 0, 0, 0, 1, 1);
        chk(status[19] == 1, "R8", "bus off held in reset mode", status[19], 1);
        reset_mode = 0;
        // R10: dominant bit restarts the run but keeps completed runs
        for (int i = 0; i < 127 * 11 + 10; i++) step(0, 0, 0, 0, 1, 1);
        chk(status[19] == 1, "R9", "one bit short", status[19], 1);
        step(0, 0, 0, 0, 0, 1);
        chk(status[19] == 1, "R10", "untimed recessive ignored", status[19], 1);
        step(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 1);
        chk(status[19] == 1, "R10", "run restarted by dominant", status[19], 1);
        step(0, 0, 0, 0, 1, 1);
        // R9: recovery complete
        chk_status("R9");
        chk(status === 32'h0, "R9", "cleared after recovery", status, 0);
        step(0, 0, 0, 0, 0, 0);
        chk(exp_q.size() == 0, "R6", "all expected pulses seen", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule